// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This block holds the program counter of a simple 32-bit RISC core. In every cycle it works out the address of the next instruction word. The inputs are a decoded instruction class, the two immediate fields, the register operands A and B, an exception-return address and a condition code. The block updates its program counter only on cycles where the pipeline asserts the advance strobe, so the core can stall it.

The block also produces the link-register write requested by calls and by the next-PC instruction: an enable, a register index and the data. The register file sits outside the block and applies that write.

For a return, the decoder places register 31 on operand A. An absolute jump keeps the top four PC bits and fills the remaining bits from a 26-bit word index. A relative branch is measured from PC+4, and the low two bits of its offset are forced to zero.

Top module: `pcseq_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` is loaded with the parameter `RESET_VEC` (default 0x00000100).
- R2: When `adv_i` is low, `pc_o` keeps its value across the clock edge and `lnk_we_o` is low, whatever the class.
- R3: Class 0 (sequential), and every class code from 10 to 15, gives a next PC of PC+4.
- R4: Class 1 (unconditional relative branch) gives a next PC of PC+4 plus the sign-extended `imm16_i` with bits 1:0 cleared.
- R5: Class 2 (conditional branch) takes the R4 target when its condition holds, and PC+4 otherwise. The condition is set by `cond_i`: 0 = signed A>=B, 1 = signed A<B, 2 = A!=B, 3 = A==B, 4 = unsigned A>=B, 5 = unsigned A<B. Codes 6 and 7 are never taken.
- R6: Class 3 (absolute jump) gives a next PC of {PC[31:28], `imm26_i`, 2'b00}.
- R7: Class 4 (call) jumps to the R6 target and requests a write of PC+4 into register 31.
- R8: Class 5 (register jump) and class 6 (return) give a next PC equal to `rega_i`. Neither class requests a link write.
- R9: Class 7 (indirect call) gives a next PC equal to `rega_i` and requests a write of PC+4 into register 31.
- R10: Class 8 (next-PC) advances to PC+4 and requests a write of PC+4 into register `rc_i`. The request is suppressed when `rc_i` is 0.
- R11: Class 9 (exception return) gives a next PC equal to `eret_addr_i`.
- R12: `lnk_we_o` is high only for classes 4, 7 and 8 while `adv_i` is high.
- R13: After every edge where `adv_i` is high and `rst` is low, `pc_o` equals the value `next_pc_o` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance strobe; the program counter updates only while this is high |
| cls_i | input | 4 | Decoded instruction class |
| cond_i | input | 3 | Branch condition code |
| imm16_i | input | 16 | Branch offset field |
| imm26_i | input | 26 | Absolute jump word index |
| rc_i | input | 5 | Destination register index for next-PC |
| rega_i | input | 32 | Register operand A |
| regb_i | input | 32 | Register operand B |
| eret_addr_i | input | 32 | Exception return address |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Next fetch address (combinational) |
| lnk_we_o | output | 1 | Link write enable |
| lnk_idx_o | output | 5 | Link write register index |
| lnk_data_o | output | 32 | Link write data (PC+4) |

## Verification
`next_pc_o` and the link-write outputs are combinational, so they are valid in the same cycle as the inputs that produce them. `pc_o` changes only at the next rising edge, one register stage later. The driver applies inputs on the falling edge and checks the combinational outputs one time unit later. It pushes the expected program counter into a queue, and the monitor pops that entry two time units after the following rising edge and compares it with `pc_o`. Stall cycles push the unchanged value, so each stimulus has exactly one queue entry in order.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PC_W     = 32;
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;
    localparam int RIDX_W   = 5;
    localparam int CLS_W    = 4;
    localparam int CC_W     = 3;
    localparam int REGION_W = PC_W - JIDX_W - 2;
    localparam int STEP     = 4;
    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(31);
    localparam logic [RIDX_W-1:0] ZERO_REG = '0;

    typedef enum logic [CLS_W-1:0] {
        CLS_SEQ   = 4'd0,
        CLS_BRU   = 4'd1,
        CLS_BRC   = 4'd2,
        CLS_JABS  = 4'd3,
        CLS_CALL  = 4'd4,
        CLS_JREG  = 4'd5,
        CLS_RET   = 4'd6,
        CLS_CALLR = 4'd7,
        CLS_NXPC  = 4'd8,
        CLS_ERET  = 4'd9
    } pc_cls_e;

    // Candidate addresses prepared every cycle
    typedef struct packed {
        logic [PC_W-1:0] seq;
        logic [PC_W-1:0] rel;
        logic [PC_W-1:0] abs;
    } pc_cand_t;

    // Link register write request
    typedef struct packed {
        logic              we;
        logic [RIDX_W-1:0] idx;
        logic [PC_W-1:0]   data;
    } link_req_t;

    // Sign-extended branch offset with word alignment forced
    function automatic logic [PC_W-1:0] rel_offset(input logic [IMM_W-1:0] imm);
        logic [PC_W-1:0] ext;
        ext = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};
        return {ext[PC_W-1:2], 2'b00};
    endfunction

    // Region-preserving absolute target
    function automatic logic [PC_W-1:0] abs_target(input logic [PC_W-1:0] pc,
                                                  input logic [JIDX_W-1:0] idx);
        return {pc[PC_W-1 -: REGION_W], idx, 2'b00};
    endfunction

    function automatic logic is_link_class(input pc_cls_e c);
        return (c == CLS_CALL) || (c == CLS_CALLR) || (c == CLS_NXPC);
    endfunction

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
    import pcseq_pkg::*;
#(
    parameter logic [CC_W-1:0] CC_GE  = 3'd0,
    parameter logic [CC_W-1:0] CC_LT  = 3'd1,
    parameter logic [CC_W-1:0] CC_NE  = 3'd2,
    parameter logic [CC_W-1:0] CC_EQ  = 3'd3,
    parameter logic [CC_W-1:0] CC_GEU = 3'd4,
    parameter logic [CC_W-1:0] CC_LTU = 3'd5
) (
    input  logic [CC_W-1:0] cond_i,
    input  logic [PC_W-1:0] opa_i,
    input  logic [PC_W-1:0] opb_i,
    output logic            take_o
);

    logic slt;
    logic ult;
    logic eq;

    always_comb begin
        slt = $signed(opa_i) < $signed(opb_i);
        ult = opa_i < opb_i;
        eq  = opa_i == opb_i;
    end

    always_comb begin
        if (cond_i == CC_GE)       take_o = ~slt;
        else if (cond_i == CC_LT)  take_o = slt;
        else if (cond_i == CC_NE)  take_o = ~eq;
        else if (cond_i == CC_EQ)  take_o = eq;
        else if (cond_i == CC_GEU) take_o = ~ult;
        else if (cond_i == CC_LTU) take_o = ult;
        else                       take_o = 1'b0;
    end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
(
    input  logic [PC_W-1:0]   pc_i,
    input  logic [IMM_W-1:0]  imm16_i,
    input  logic [JIDX_W-1:0] imm26_i,
    output pc_cand_t          cand_o
);

    logic [PC_W-1:0] seq_addr;

    always_comb begin
        seq_addr    = pc_i + PC_W'(STEP);
        cand_o.seq  = seq_addr;
        cand_o.rel  = seq_addr + rel_offset(imm16_i);
        cand_o.abs  = abs_target(pc_i, imm26_i);
    end

endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
    import pcseq_pkg::*;
(
    input  pc_cls_e           cls_i,
    input  logic              adv_i,
    input  logic              take_i,
    input  pc_cand_t          cand_i,
    input  logic [RIDX_W-1:0] rc_i,
    input  logic [PC_W-1:0]   rega_i,
    input  logic [PC_W-1:0]   eret_addr_i,
    output logic [PC_W-1:0]   next_o,
    output link_req_t         link_o
);

    always_comb begin
        next_o = cand_i.seq;
        unique case (cls_i)
            CLS_BRU:   next_o = cand_i.rel;
            CLS_BRC:   next_o = take_i ? cand_i.rel : cand_i.seq;
            CLS_JABS,
            CLS_CALL:  next_o = cand_i.abs;
            CLS_JREG,
            CLS_RET,
            CLS_CALLR: next_o = rega_i;
            CLS_ERET:  next_o = eret_addr_i;
            default:   next_o = cand_i.seq;
        endcase
    end

    always_comb begin
        link_o.data = cand_i.seq;
        link_o.idx  = (cls_i == CLS_NXPC) ? rc_i : LINK_REG;
        link_o.we   = adv_i && is_link_class(cls_i) && (link_o.idx != ZERO_REG);
    end

endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
    import pcseq_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_0100,
    parameter logic [CC_W-1:0] CC_GE  = 3'd0,
    parameter logic [CC_W-1:0] CC_LT  = 3'd1,
    parameter logic [CC_W-1:0] CC_NE  = 3'd2,
    parameter logic [CC_W-1:0] CC_EQ  = 3'd3,
    parameter logic [CC_W-1:0] CC_GEU = 3'd4,
    parameter logic [CC_W-1:0] CC_LTU = 3'd5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic [CC_W-1:0]   cond_i,
    input  logic [IMM_W-1:0]  imm16_i,
    input  logic [JIDX_W-1:0] imm26_i,
    input  logic [RIDX_W-1:0] rc_i,
    input  logic [PC_W-1:0]   rega_i,
    input  logic [PC_W-1:0]   regb_i,
    input  logic [PC_W-1:0]   eret_addr_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              lnk_we_o,
    output logic [RIDX_W-1:0] lnk_idx_o,
    output logic [PC_W-1:0]   lnk_data_o
);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] next_pc;
    logic            take;
    pc_cand_t        cand;
    link_req_t       link;
    pc_cls_e         cls;

    assign cls = pc_cls_e'(cls_i);

    pcseq_cond #(
        .CC_GE (CC_GE),
        .CC_LT (CC_LT),
        .CC_NE (CC_NE),
        .CC_EQ (CC_EQ),
        .CC_GEU(CC_GEU),
        .CC_LTU(CC_LTU)
    ) u_cond (
        .cond_i(cond_i),
        .opa_i (rega_i),
        .opb_i (regb_i),
        .take_o(take)
    );

    pcseq_target u_target (
        .pc_i   (pc_q),
        .imm16_i(imm16_i),
        .imm26_i(imm26_i),
        .cand_o (cand)
    );

    pcseq_select u_select (
        .cls_i      (cls),
        .adv_i      (adv_i),
        .take_i     (take),
        .cand_i     (cand),
        .rc_i       (rc_i),
        .rega_i     (rega_i),
        .eret_addr_i(eret_addr_i),
        .next_o     (next_pc),
        .link_o     (link)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_VEC;
        end else if (adv_i) begin
            pc_q <= next_pc;
        end
    end

    assign pc_o       = pc_q;
    assign next_pc_o  = next_pc;
    assign lnk_we_o   = link.we;
    assign lnk_idx_o  = link.idx;
    assign lnk_data_o = link.data;

endmodule

// File: rtl/pcseq_unit_chk.sv
module pcseq_unit_chk
    import pcseq_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_0100
) (
    input logic              clk,
    input logic              rst,
    input logic              adv_i,
    input logic [CLS_W-1:0]  cls_i,
    input logic [RIDX_W-1:0] rc_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [PC_W-1:0]   next_pc_o,
    input logic              lnk_we_o,
    input logic [RIDX_W-1:0] lnk_idx_o,
    input logic [PC_W-1:0]   lnk_data_o
);

    // R1
    a_r1_reset_vector: assert property (@(posedge clk) rst |=> pc_o == RESET_VEC);

    // R2
    a_r2_stall_holds: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(pc_o));

    // R3
    a_r3_seq_step: assert property (@(posedge clk) disable iff (rst)
        (adv_i && cls_i == 4'd0) |=> pc_o == $past(pc_o) + 32'd4);

    // R10
    a_r10_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 4'd8 && rc_i == '0) |-> !lnk_we_o);

    // R12
    a_r12_link_only_when_advancing: assert property (@(posedge clk) disable iff (rst)
        lnk_we_o |-> adv_i && (cls_i == 4'd4 || cls_i == 4'd7 || cls_i == 4'd8));

    // R7, R9
    a_r7_link_data_seq: assert property (@(posedge clk) disable iff (rst)
        lnk_we_o |-> lnk_data_o == pc_o + 32'd4);

    // R13
    a_r13_next_commits: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> pc_o == $past(next_pc_o));

    // R7
    a_r7_call_idx: assert property (@(posedge clk) disable iff (rst)
        (lnk_we_o && cls_i == 4'd4) |-> lnk_idx_o == 5'd31);

endmodule

bind pcseq_unit pcseq_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv_i     (adv_i),
    .cls_i     (cls_i),
    .rc_i      (rc_i),
    .pc_o      (pc_o),
    .next_pc_o (next_pc_o),
    .lnk_we_o  (lnk_we_o),
    .lnk_idx_o (lnk_idx_o),
    .lnk_data_o(lnk_data_o)
);

// File: tb/pcseq_unit_bench.sv
module pcseq_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RVEC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_i = 1'b0;
    logic [3:0]  cls_i = '0;
    logic [2:0]  cond_i = '0;
    logic [15:0] imm16_i = '0;
    logic [25:0] imm26_i = '0;
    logic [4:0]  rc_i = '0;
    logic [31:0] rega_i = '0;
    logic [31:0] regb_i = '0;
    logic [31:0] eret_addr_i = '0;
    logic [31:0] pc_o;
    logic [31:0] next_pc_o;
    logic        lnk_we_o;
    logic [4:0]  lnk_idx_o;
    logic [31:0] lnk_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] mpc;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcseq_unit #(.RESET_VEC(RVEC)) u_pcseq_unit (
        .clk(clk), .rst(rst), .adv_i(adv_i), .cls_i(cls_i), .cond_i(cond_i),
        .imm16_i(imm16_i), .imm26_i(imm26_i), .rc_i(rc_i), .rega_i(rega_i),
        .regb_i(regb_i), .eret_addr_i(eret_addr_i), .pc_o(pc_o),
        .next_pc_o(next_pc_o), .lnk_we_o(lnk_we_o), .lnk_idx_o(lnk_idx_o),
        .lnk_data_o(lnk_data_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic cond_model(input logic [2:0] cc, input logic [31:0] a, input logic [31:0] b);
        case (cc)
            3'd0: return $signed(a) >= $signed(b);
            3'd1: return $signed(a) <  $signed(b);
            3'd2: return a != b;
            3'd3: return a == b;
            3'd4: return a >= b;
            3'd5: return a <  b;
            default: return 1'b0;
        endcase
    endfunction

    // Driver: apply one instruction, check combinational results, queue expected PC
    task automatic step(input string tag, input logic [3:0] c, input logic [2:0] cc,
                        input logic [15:0] i16, input logic [25:0] i26, input logic [4:0] rc,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] ea,
                        input logic adv);
        logic [31:0] seq, rel, abs, nxt;
        logic        we;
        logic [4:0]  idx;
        @(negedge clk);
        cls_i = c; cond_i = cc; imm16_i = i16; imm26_i = i26; rc_i = rc;
        rega_i = a; regb_i = b; eret_addr_i = ea; adv_i = adv;
        #1;
        seq = mpc + 32'd4;
        rel = seq + {{16{i16[15]}}, i16[15:2], 2'b00};
        abs = {mpc[31:28], i26, 2'b00};
        we = 1'b0; idx = 5'd31;
        case (c)
            4'd1: nxt = rel;
            4'd2: nxt = cond_model(cc, a, b) ? rel : seq;
            4'd3: nxt = abs;
            4'd4: begin nxt = abs; we = 1'b1; end
            4'd5, 4'd6: nxt = a;
            4'd7: begin nxt = a; we = 1'b1; end
            4'd8: begin nxt = seq; idx = rc; we = (rc != 5'd0); end
            4'd9: nxt = ea;
            default: nxt = seq;
        endcase
        we = we & adv;
        check({tag, " next_pc"}, next_pc_o, nxt);
        check({tag, " lnk_we"}, {31'd0, lnk_we_o}, {31'd0, we});
        if (we) begin
            check({tag, " lnk_idx"}, {27'd0, lnk_idx_o}, {27'd0, idx});
            check({tag, " lnk_data"}, lnk_data_o, seq);
        end
        if (adv) mpc = nxt;
        exp_q.push_back(mpc);
        tag_q.push_back({tag, " pc"});
    endtask

    // Monitor: compare registered PC after each edge
    always @(posedge clk) begin
        #2;
        if (!rst && exp_q.size() > 0) begin
            check(tag_q.pop_front(), pc_o, exp_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pc", pc_o, RVEC);
        rst = 1'b0;
        mpc = RVEC;
        // R3 sequential and undefined classes
        step("R3 seq",        4'd0, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        step("R3 seq",        4'd0, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        step("R3 class 12",   4'd12, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        step("R3 class 15",   4'd15, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        // R2 stall with a call pending
        step("R2 stall call", 4'd4, 3'd0, 16'h0, 26'h123, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0);
        step("R2 stall seq",  4'd0, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b0);
        // R4 relative branches, low bits masked
        step("R4 bru fwd",    4'd1, 3'd0, 16'h0043, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        step("R4 bru back",   4'd1, 3'd0, 16'hFFF7, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        // R5 each condition taken and not taken
        step("R5 ge s taken", 4'd2, 3'd0, 16'h0010, 26'h0, 5'd0, 32'd5, 32'hFFFF_FFFF, 32'h0, 1'b1);
        step("R5 ge s fall",  4'd2, 3'd0, 16'h0010, 26'h0, 5'd0, 32'hFFFF_FFFF, 32'd1, 32'h0, 1'b1);
        step("R5 lt s taken", 4'd2, 3'd1, 16'h0020, 26'h0, 5'd0, 32'hFFFF_FFFF, 32'd1, 32'h0, 1'b1);
        step("R5 lt s fall",  4'd2, 3'd1, 16'h0020, 26'h0, 5'd0, 32'd7, 32'd7, 32'h0, 1'b1);
        step("R5 ne taken",   4'd2, 3'd2, 16'hFFF0, 26'h0, 5'd0, 32'd7, 32'd8, 32'h0, 1'b1);
        step("R5 ne fall",    4'd2, 3'd2, 16'hFFF0, 26'h0, 5'd0, 32'd7, 32'd7, 32'h0, 1'b1);
        step("R5 eq taken",   4'd2, 3'd3, 16'h0008, 26'h0, 5'd0, 32'd9, 32'd9, 32'h0, 1'b1);
        step("R5 eq fall",    4'd2, 3'd3, 16'h0008, 26'h0, 5'd0, 32'd9, 32'd3, 32'h0, 1'b1);
        step("R5 geu taken",  4'd2, 3'd4, 16'h0030, 26'h0, 5'd0, 32'hFFFF_FFFF, 32'd1, 32'h0, 1'b1);
        step("R5 geu fall",   4'd2, 3'd4, 16'h0030, 26'h0, 5'd0, 32'd1, 32'hFFFF_FFFF, 32'h0, 1'b1);
        step("R5 ltu taken",  4'd2, 3'd5, 16'h0030, 26'h0, 5'd0, 32'd1, 32'hFFFF_FFFF, 32'h0, 1'b1);
        step("R5 ltu fall",   4'd2, 3'd5, 16'h0030, 26'h0, 5'd0, 32'hFFFF_FFFF, 32'd1, 32'h0, 1'b1);
        step("R5 code 6",     4'd2, 3'd6, 16'h0030, 26'h0, 5'd0, 32'd1, 32'd1, 32'h0, 1'b1);
        step("R5 code 7",     4'd2, 3'd7, 16'h0030, 26'h0, 5'd0, 32'd1, 32'd2, 32'h0, 1'b1);
        // R11 exception return into a high region
        step("R11 eret",      4'd9, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0, 32'h0, 32'hA000_1000, 1'b1);
        // R6 absolute jump keeps region bits
        step("R6 jabs",       4'd3, 3'd0, 16'h0, 26'h3FF_FFFF, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        // R7 call
        step("R7 call",       4'd4, 3'd0, 16'h0, 26'h000_4321, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        // R8 register jump and return
        step("R8 jreg",       4'd5, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0000_2000, 32'h0, 32'h0, 1'b1);
        step("R8 ret",        4'd6, 3'd0, 16'h0, 26'h0, 5'd0, 32'h1234_5678, 32'h0, 32'h0, 1'b1);
        // R9 indirect call
        step("R9 callr",      4'd7, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0000_0800, 32'h0, 32'h0, 1'b1);
        // R10 next-PC, with and without suppression
        step("R10 nextpc r5", 4'd8, 3'd0, 16'h0, 26'h0, 5'd5, 32'h0, 32'h0, 32'h0, 1'b1);
        step("R10 nextpc r0", 4'd8, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        // R12 stalled indirect call writes nothing
        step("R12 stall callr", 4'd7, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0000_4000, 32'h0, 32'h0, 1'b0);
        step("R13 seq",       4'd0, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        // R1 reset mid-run
        @(negedge clk);
        adv_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", pc_o, RVEC);
        rst = 1'b0;
        mpc = RVEC;
        step("R3 after reset", 4'd0, 3'd0, 16'h0, 26'h0, 5'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        repeat (3) @(negedge clk);
        check("R13 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule